// File: doc/BRIEF.md
# Fast-Charge Handshake Controller

This block is the digital core of a USB charging port that can raise its output above 5 V for a device that asks for it. Analog comparators outside the block reduce each data line to a two-bit level code. A supply-good flag tells the block when its own supply is valid. A slow prescaled tick, nominally 1 ms, serves as the time base for every long delay. The block drives five switch enables. The first is a switch that shorts D+ to D-. The second is a pull-down switch on D-. The other three set the output voltage through the power stage's feedback network.

After power-up the port acts as a plain 5 V dedicated charger, with D+ and D- shorted. If a device holds D+ up without a break for a long qualification window, the port takes it as a fast-charge capable device. The port then opens the short and applies the D- pull-down. It waits until D- has been low for a short time, and after that it accepts voltage requests. Each request is coded as a level pair on D+ and D-. It must stay stable for a debounce window before the port maps it onto the three select enables. Two strap inputs can block the upper voltage classes. If D+ drops while the port is in fast-charge mode, the cable has gone, and the port returns to the 5 V default.

Top module: `fcp_handshake`

## Requirements
- R1: While `rst_n` is low or `supply_ok` is low, all five enables are off. On the first clock edge with `supply_ok` high, `sw_short` turns on and the other four enables stay off.
- R2: Level codes are 0 = below 0.325 V, 1 = about 0.6 V, 2 = about 3.3 V, and 3 = invalid. The D+ level counts as "up" for any code other than 0. The port leaves the shorted state on the clock edge of the QUAL_TICKS-th tick seen with D+ up, and not on any earlier one.
- R3: A single clock with D+ at code 0 during qualification restarts the tick count from zero, and the port stays in the shorted state.
- R4: On entering fast-charge mode, `sw_short` turns off and `sw_dm_pd` turns on in the same cycle.
- R5: After entry, no request changes `vsel` until D- has been at code 0 for DM_TICKS consecutive ticks.
- R6: Requests map onto `vsel` as follows (`vsel[2:0]`, bit 0 is the first enable):
  - D+=1, D-=0 selects 5 V, `vsel=000`.
  - D+=2, D-=1 selects 9 V, `vsel=001`.
  - D+=1, D-=1 selects 12 V, `vsel=011`.
  - D+=2, D-=2 selects 20 V, `vsel=111`.
- R7: While `inh_12` is high, 12 V and 20 V requests are refused. While `inh_20` is high, 20 V requests are refused. A refused request leaves `vsel` unchanged.
- R8: In fast-charge mode, D+ at code 0 means disconnect. On the next edge `sw_short` is on and `sw_dm_pd` and `vsel` are off.
- R9: Dropping `supply_ok` at any point turns all enables off on the next edge, and the power-up sequence starts again.
- R10: A level pair takes effect only on the DEB_TICKS-th tick after it last changed. A change of the pair restarts that count.
- R11: A level pair not listed in R6 leaves `vsel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the timing prescaler |
| supply_ok | input | 1 | Supply valid; low holds the block at power-up state |
| dp_lvl | input | 2 | D+ comparator level code |
| dm_lvl | input | 2 | D- comparator level code |
| inh_12 | input | 1 | Refuse 12 V and 20 V requests |
| inh_20 | input | 1 | Refuse 20 V requests |
| sw_short | output | 1 | D+/D- short switch enable |
| sw_dm_pd | output | 1 | D- pull-down switch enable |
| vsel | output | 3 | Voltage-select switch enables |

## Verification
On every cycle, the assertions check the following:
- the power-down and disconnect fallbacks;
- that the short switch never coexists with the pull-down or a select enable;
- that the select code stays within the four legal patterns;
- that an asserted inhibit never lets its select bit rise.

Only the bench scenarios can show the exact tick counts. These are qualification length and restart after a glitch, the D- wait before requests, and the debounce window. The bench also shows the full request-to-code mapping under each inhibit combination.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LV_LOW  = 2'd0;
  localparam lvl_t LV_MID  = 2'd1;
  localparam lvl_t LV_HIGH = 2'd2;

  typedef enum logic [1:0] {ST_OFF, ST_SHORT, ST_DMWAIT, ST_ACTIVE} hs_state_e;
  typedef enum logic [1:0] {V_5, V_9, V_12, V_20} vset_e;

  typedef struct packed {
    logic  known;
    vset_e v;
  } req_t;

  // Map a D+/D- level pair onto a voltage class.
  function automatic req_t decode_req(lvl_t dp, lvl_t dm);
    req_t r;
    r.known = 1'b1;
    r.v     = V_5;
    if      (dp == LV_MID  && dm == LV_LOW)  r.v = V_5;
    else if (dp == LV_HIGH && dm == LV_MID)  r.v = V_9;
    else if (dp == LV_MID  && dm == LV_MID)  r.v = V_12;
    else if (dp == LV_HIGH && dm == LV_HIGH) r.v = V_20;
    else r.known = 1'b0;
    return r;
  endfunction

  // Inhibit cascade: the 12 V strap also blocks 20 V.
  function automatic logic class_allowed(vset_e v, logic i12, logic i20);
    case (v)
      V_12:    return !i12;
      V_20:    return !i12 && !i20;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [2:0] vsel_of(vset_e v);
    case (v)
      V_9:     return 3'b001;
      V_12:    return 3'b011;
      V_20:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/fcp_tick_timer.sv
// Counts prescaler ticks while a level holds; any break restarts it.
module fcp_tick_timer #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic level_ok,
  input  logic tick,
  output logic done
);
  localparam int W = (N < 2) ? 1 : $clog2(N + 1);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || !level_ok) cnt_q <= '0;
    else if (tick && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && level_ok && tick && (cnt_q == LAST);
endmodule

// File: rtl/fcp_req_filter.sv
// Holds the last seen level pair and fires once after DEB ticks of stability.
module fcp_req_filter #(
  parameter int DEB = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [3:0] pair_in,
  output logic [3:0] pair_q,
  output logic       apply
);
  localparam int W = (DEB < 2) ? 1 : $clog2(DEB + 1);
  localparam logic [W-1:0] LAST = W'(DEB - 1);
  localparam logic [W-1:0] SAT  = W'(DEB);

  logic [W-1:0] cnt_q;
  logic         same;

  assign same = (pair_in == pair_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      cnt_q  <= '0;
    end else if (!run || !same) begin
      pair_q <= pair_in;
      cnt_q  <= '0;
    end else if (tick && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign apply = run && same && tick && (cnt_q == LAST);
endmodule

// File: rtl/fcp_handshake.sv
module fcp_handshake
  import fcp_pkg::*;
#(
  parameter int QUAL_TICKS = 1250,
  parameter int DM_TICKS   = 1,
  parameter int DEB_TICKS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic [1:0] dp_lvl,
  input  logic [1:0] dm_lvl,
  input  logic       inh_12,
  input  logic       inh_20,
  output logic       sw_short,
  output logic       sw_dm_pd,
  output logic [2:0] vsel
);

  hs_state_e state_q, state_d;
  vset_e     vset_q;

  // Named internal events.
  logic dp_low, dm_low, qual_done, dm_done, req_apply, req_allowed;
  logic [3:0] pair_q;
  req_t req;

  assign dp_low = (dp_lvl == LV_LOW);
  assign dm_low = (dm_lvl == LV_LOW);

  fcp_tick_timer #(.N(QUAL_TICKS)) qual_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SHORT),
    .level_ok(!dp_low), .tick(tick), .done(qual_done));

  fcp_tick_timer #(.N(DM_TICKS)) dm_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DMWAIT),
    .level_ok(dm_low), .tick(tick), .done(dm_done));

  fcp_req_filter #(.DEB(DEB_TICKS)) filt_i (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_ACTIVE), .tick(tick),
    .pair_in({dp_lvl, dm_lvl}), .pair_q(pair_q), .apply(req_apply));

  assign req         = decode_req(pair_q[3:2], pair_q[1:0]);
  assign req_allowed = req.known && class_allowed(req.v, inh_12, inh_20);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:    state_d = ST_SHORT;
      ST_SHORT:  if (qual_done) state_d = ST_DMWAIT;
      ST_DMWAIT: if (dp_low) state_d = ST_SHORT;
                 else if (dm_done) state_d = ST_ACTIVE;
      ST_ACTIVE: if (dp_low) state_d = ST_SHORT;
      default:   state_d = ST_OFF;
    endcase
    if (!supply_ok) state_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      vset_q  <= V_5;
    end else begin
      state_q <= state_d;
      if (state_d != ST_ACTIVE)          vset_q <= V_5;
      else if (req_apply && req_allowed) vset_q <= req.v;
    end
  end

  assign sw_short = (state_q == ST_SHORT);
  assign sw_dm_pd = (state_q == ST_DMWAIT) || (state_q == ST_ACTIVE);
  assign vsel     = vsel_of(vset_q);

endmodule

// File: rtl/fcp_handshake_chk.sv
module fcp_handshake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic [1:0] dp_lvl,
  input logic       inh_12,
  input logic       inh_20,
  input logic       sw_short,
  input logic       sw_dm_pd,
  input logic [2:0] vsel
);
  a_r1_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!sw_short && !sw_dm_pd && vsel == 3'b000));

  a_r4_short_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    sw_short |-> (!sw_dm_pd && vsel == 3'b000));

  a_r4_entry_from_short: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_dm_pd) |-> $past(sw_short));

  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel == 3'b000 || vsel == 3'b001 || vsel == 3'b011 || vsel == 3'b111));

  a_r6_select_needs_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel != 3'b000) |-> sw_dm_pd);

  a_r7_inh12_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_12 && !vsel[1]) |=> !vsel[1]);

  a_r7_inh20_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_20 && !vsel[2]) |=> !vsel[2]);

  a_r8_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && sw_dm_pd && dp_lvl == 2'b00) |=>
      (sw_short && !sw_dm_pd && vsel == 3'b000));
endmodule

bind fcp_handshake fcp_handshake_chk chk_i (.*);

// File: tb/fcp_handshake_tb_top.sv
module fcp_handshake_tb_top;
  localparam int CLK_P = 10;
  localparam int QUAL  = 8;
  localparam int DMT   = 3;
  localparam int DEB   = 4;

  logic clk = 0, rst_n = 0, tick = 0, supply_ok = 0;
  logic [1:0] dp_lvl = 0, dm_lvl = 0;
  logic inh_12 = 0, inh_20 = 0;
  logic sw_short, sw_dm_pd;
  logic [2:0] vsel;
  int checks = 0, fails = 0;

  fcp_handshake #(.QUAL_TICKS(QUAL), .DM_TICKS(DMT), .DEB_TICKS(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .dp_lvl(dp_lvl), .dm_lvl(dm_lvl), .inh_12(inh_12), .inh_20(inh_20),
    .sw_short(sw_short), .sw_dm_pd(sw_dm_pd), .vsel(vsel));

  always #(CLK_P/2) clk = ~clk;

  // {dp, dm, inh_12, inh_20, expected vsel}
  localparam logic [8:0] VEC [13] = '{
    {2'd2, 2'd1, 1'b0, 1'b0, 3'b001},  // R6 9 V
    {2'd1, 2'd1, 1'b0, 1'b0, 3'b011},  // R6 12 V
    {2'd2, 2'd2, 1'b0, 1'b0, 3'b111},  // R6 20 V
    {2'd1, 2'd0, 1'b0, 1'b0, 3'b000},  // R6 5 V
    {2'd2, 2'd2, 1'b0, 1'b1, 3'b000},  // R7 20 V refused
    {2'd1, 2'd1, 1'b0, 1'b1, 3'b011},  // R7 12 V allowed
    {2'd2, 2'd2, 1'b0, 1'b1, 3'b011},  // R7 20 V refused, hold
    {2'd2, 2'd1, 1'b1, 1'b0, 3'b001},  // R7 9 V allowed
    {2'd1, 2'd1, 1'b1, 1'b0, 3'b001},  // R7 12 V refused
    {2'd2, 2'd2, 1'b1, 1'b0, 3'b001},  // R7 cascade blocks 20 V
    {2'd2, 2'd0, 1'b0, 1'b0, 3'b001},  // R11 unknown pair
    {2'd3, 2'd1, 1'b0, 1'b0, 3'b001},  // R11 invalid code
    {2'd1, 2'd1, 1'b0, 1'b0, 3'b011}   // R6 12 V again
  };

  task automatic cyc(input logic t);
    tick = t;
    @(posedge clk);
    #2;
    tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {sw_short, sw_dm_pd, vsel};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: short/pd/vsel actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) cyc(1'b0);
    chk("R1 in reset", 5'b00000);
    rst_n = 1;
    cyc(1'b0); cyc(1'b0);
    chk("R1 supply low", 5'b00000);
    supply_ok = 1;
    cyc(1'b0);
    chk("R1 short on", 5'b10000);

    // Qualification
    dp_lvl = 2'd1; dm_lvl = 2'd1;
    ticks(QUAL - 1);
    chk("R2 before full window", 5'b10000);
    dp_lvl = 2'd0; cyc(1'b1);
    dp_lvl = 2'd1;
    ticks(QUAL - 1);
    chk("R3 restart after dip", 5'b10000);
    ticks(1);
    chk("R2 R4 entry", 5'b01000);

    // D- still high: a 12 V pattern must be ignored
    ticks(DEB + DMT + 4);
    chk("R5 request before D- low", 5'b01000);
    dp_lvl = 2'd1; dm_lvl = 2'd0;
    ticks(DMT + DEB + 1);
    chk("R5 active at 5 V", 5'b01000);

    foreach (VEC[k]) begin
      logic [2:0] prev;
      prev = vsel;
      dp_lvl = VEC[k][8:7]; dm_lvl = VEC[k][6:5];
      inh_12 = VEC[k][4];   inh_20 = VEC[k][3];
      cyc(1'b1);
      ticks(DEB - 1);
      chk("R10 debounce hold", {2'b01, prev});
      ticks(1);
      chk("R6 R7 R11 vector", {2'b01, VEC[k][2:0]});
    end
    inh_12 = 0; inh_20 = 0;

    // Debounce restart: 20 V pattern broken by one glitch cycle
    dp_lvl = 2'd2; dm_lvl = 2'd2;
    cyc(1'b0); ticks(DEB - 2);
    dm_lvl = 2'd1; cyc(1'b0);
    dm_lvl = 2'd2; cyc(1'b0);
    ticks(DEB - 1);
    chk("R10 restart after change", 5'b01011);
    ticks(1);
    chk("R10 applied", 5'b01111);

    // Disconnect
    dp_lvl = 2'd0; cyc(1'b0);
    chk("R8 disconnect", 5'b10000);

    // Requalify, then lose supply
    dp_lvl = 2'd1; dm_lvl = 2'd1;
    ticks(QUAL);
    chk("R4 requalified", 5'b01000);
    supply_ok = 0; cyc(1'b0);
    chk("R9 supply loss", 5'b00000);
    supply_ok = 1; cyc(1'b0);
    chk("R9 restart", 5'b10000);

    report();
  end
endmodule